// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a shared memory and judges load-reserved / store-conditional traffic from several bus masters. It keeps one reservation per master: a valid flag plus the address of an aligned 8-byte granule. Each cycle, every master can present one data-phase request, made up of a valid strobe, an address, a write flag, an exclusive flag and that transfer's bus error status. In the same cycle the block answers with an exclusive-okay flag for that master. It also raises a write-suppress flag, which tells the memory to drop a store-conditional that lost its reservation. The reservations change on the clock edge that closes the data phase.

A single enable bit switches the monitor on or off. It is written through a small register port. While the monitor is off, every access reports exclusive-okay and the reservations are frozen. When two masters present requests in the same cycle, the block handles master 0 first and master 1 second. A store from master 0 therefore removes a matching reservation of master 1 before master 1's request is judged.

Top module: `excl_monitor`

## Requirements
- R1: A synchronous active-high reset clears the enable bit and every reservation. After reset, idle cycles report exclusive-okay high. Once the monitor is enabled, an exclusive write with no exclusive read before it fails.
- R2: A register write with `cfg_addr` equal to 0x18 sets the enable bit when `cfg_wdata` is nonzero and clears it when `cfg_wdata` is zero. A write at any other offset leaves the bit unchanged. The new value applies from the next cycle.
- R3: With the monitor enabled, an exclusive read always reports exclusive-okay high. It marks its own master's reservation valid and records the address with bits [2:0] cleared.
- R4: With the monitor enabled, an exclusive write reports exclusive-okay high only when its own master's reservation is valid and the recorded granule equals the write address with bits [2:0] cleared. Any byte address inside the same 8-byte granule matches.
- R5: An enabled exclusive write clears its own master's reservation, whether it succeeds or fails.
- R6: A successful exclusive write clears every other master's reservation whose granule matches. Reservations on other granules stay valid.
- R7: With the monitor enabled, a plain write reports exclusive-okay low. It clears every other master's matching reservation and leaves its own reservation intact.
- R8: With the monitor enabled, a plain read reports exclusive-okay low and changes no reservation.
- R9: `wr_suppress` is high for a master exactly when that master presents a valid exclusive write that fails while the monitor is enabled.
- R10: While the monitor is disabled, valid requests without error report exclusive-okay high and `wr_suppress` low, and no reservation changes.
- R11: In a cycle where a master has no valid request, its exclusive-okay output equals the inverse of the enable bit and its `wr_suppress` is low.
- R12: A valid request flagged with a bus error reports exclusive-okay low whatever the monitor decides. The reservation update still takes place.
- R13: Requests from the same cycle are handled in master index order. The state changes caused by a lower-numbered master are visible when a higher-numbered master is judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register port write strobe |
| cfg_addr | input | CFG_AW (12) | Register port byte offset |
| cfg_wdata | input | CFG_DW (32) | Register port write data |
| req_valid | input | N_MST (2) | Per-master data phase completes this cycle |
| req_addr | input | N_MST x ADDR_W (2x32) | Per-master transfer address |
| req_write | input | N_MST | Per-master write flag |
| req_excl | input | N_MST | Per-master exclusive flag |
| req_err | input | N_MST | Per-master bus error for this transfer |
| exokay | output | N_MST | Per-master exclusive-okay response |
| wr_suppress | output | N_MST | Per-master drop-this-store indication |

## Verification
The hardest case to reach from the ports is a same-cycle collision. In it, both masters hold reservations on one granule and both present stores to that granule on a single edge. Whether master 1 fails then depends only on the processing order. Directed sequences first build the two reservations in separate cycles and then fire the colliding stores together. A random phase draws addresses from four adjacent granules, so cross-master hits, partial-granule matches and toggles of the enable bit happen often.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_XRD  = 3'd3,
    OP_XWR  = 3'd4
  } mon_op_e;

  function automatic mon_op_e classify(input logic vld, input logic wr, input logic ex);
    mon_op_e op;
    if (!vld)          op = OP_IDLE;
    else if (ex && wr) op = OP_XWR;
    else if (ex)       op = OP_XRD;
    else if (wr)       op = OP_WR;
    else               op = OP_RD;
    return op;
  endfunction

endpackage

// File: rtl/excl_mon_cfg.sv
module excl_mon_cfg #(
  parameter int                CFG_AW    = 12,
  parameter int                CFG_DW    = 32,
  parameter logic [CFG_AW-1:0] EN_OFFSET = 12'h018
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              en_q
);

  logic hit;
  assign hit = cfg_we && (cfg_addr == EN_OFFSET);

  always_ff @(posedge clk) begin
    if (rst)      en_q <= 1'b0;
    else if (hit) en_q <= |cfg_wdata;
  end

endmodule

// File: rtl/excl_mon_slots.sv
module excl_mon_slots #(
  parameter int N_MST  = 2,
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_MST-1:0]              nxt_valid,
  input  logic [N_MST-1:0][ADDR_W-1:0]  nxt_addr,
  output logic [N_MST-1:0]              cur_valid,
  output logic [N_MST-1:0][ADDR_W-1:0]  cur_addr
);

  for (genvar s = 0; s < N_MST; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        cur_valid[s] <= 1'b0;
        cur_addr[s]  <= '0;
      end else begin
        cur_valid[s] <= nxt_valid[s];
        cur_addr[s]  <= nxt_addr[s];
      end
    end
  end

endmodule

// File: rtl/excl_mon_eval.sv
module excl_mon_eval
  import excl_mon_pkg::*;
#(
  parameter int N_MST    = 2,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3
) (
  input  logic                          en,
  input  logic [N_MST-1:0]              req_valid,
  input  logic [N_MST-1:0][ADDR_W-1:0]  req_addr,
  input  logic [N_MST-1:0]              req_write,
  input  logic [N_MST-1:0]              req_excl,
  input  logic [N_MST-1:0]              req_err,
  input  logic [N_MST-1:0]              cur_valid,
  input  logic [N_MST-1:0][ADDR_W-1:0]  cur_addr,
  output logic [N_MST-1:0]              nxt_valid,
  output logic [N_MST-1:0][ADDR_W-1:0]  nxt_addr,
  output logic [N_MST-1:0]              exokay,
  output logic [N_MST-1:0]              wr_suppress
);

  localparam logic [ADDR_W-1:0] GMASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] gran;
  logic              ok;
  mon_op_e           op;

  always_comb begin
    nxt_valid   = cur_valid;
    nxt_addr    = cur_addr;
    exokay      = '0;
    wr_suppress = '0;
    gran        = '0;
    ok          = 1'b0;
    op          = OP_IDLE;
    for (int m = 0; m < N_MST; m++) begin
      gran = req_addr[m] & GMASK;
      op   = classify(req_valid[m], req_write[m], req_excl[m]);
      ok   = 1'b0;
      if (op == OP_IDLE) begin
        ok = !en;
      end else if (!en) begin
        ok = 1'b1;
      end else begin
        case (op)
          OP_XRD: begin
            ok          = 1'b1;
            nxt_valid[m] = 1'b1;
            nxt_addr[m]  = gran;
          end
          OP_XWR: begin
            ok           = nxt_valid[m] && (nxt_addr[m] == gran);
            nxt_valid[m] = 1'b0;
            wr_suppress[m] = !ok;
            if (ok) begin
              for (int k = 0; k < N_MST; k++)
                if (k != m && nxt_addr[k] == gran) nxt_valid[k] = 1'b0;
            end
          end
          OP_WR: begin
            for (int k = 0; k < N_MST; k++)
              if (k != m && nxt_addr[k] == gran) nxt_valid[k] = 1'b0;
          end
          default: ok = 1'b0;
        endcase
      end
      exokay[m] = (req_valid[m] && req_err[m]) ? 1'b0 : ok;
    end
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int                N_MST     = 2,
  parameter int                ADDR_W    = 32,
  parameter int                GRAN_LSB  = 3,
  parameter int                CFG_AW    = 12,
  parameter int                CFG_DW    = 32,
  parameter logic [CFG_AW-1:0] EN_OFFSET = 12'h018
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [CFG_DW-1:0]             cfg_wdata,
  input  logic [N_MST-1:0]              req_valid,
  input  logic [N_MST-1:0][ADDR_W-1:0]  req_addr,
  input  logic [N_MST-1:0]              req_write,
  input  logic [N_MST-1:0]              req_excl,
  input  logic [N_MST-1:0]              req_err,
  output logic [N_MST-1:0]              exokay,
  output logic [N_MST-1:0]              wr_suppress
);

  logic                         en_q;
  logic [N_MST-1:0]             cur_valid;
  logic [N_MST-1:0][ADDR_W-1:0] cur_addr;
  logic [N_MST-1:0]             nxt_valid;
  logic [N_MST-1:0][ADDR_W-1:0] nxt_addr;

  excl_mon_cfg #(
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .EN_OFFSET(EN_OFFSET)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en_q(en_q)
  );

  excl_mon_slots #(.N_MST(N_MST), .ADDR_W(ADDR_W)) u_slots (
    .clk(clk), .rst(rst), .nxt_valid(nxt_valid), .nxt_addr(nxt_addr),
    .cur_valid(cur_valid), .cur_addr(cur_addr)
  );

  excl_mon_eval #(.N_MST(N_MST), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_eval (
    .en(en_q), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_excl(req_excl), .req_err(req_err),
    .cur_valid(cur_valid), .cur_addr(cur_addr),
    .nxt_valid(nxt_valid), .nxt_addr(nxt_addr),
    .exokay(exokay), .wr_suppress(wr_suppress)
  );

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int                N_MST     = 2,
  parameter int                CFG_AW    = 12,
  parameter int                CFG_DW    = 32,
  parameter logic [CFG_AW-1:0] EN_OFFSET = 12'h018
) (
  input logic              clk,
  input logic              rst,
  input logic              en_q,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_wdata,
  input logic [N_MST-1:0]  req_valid,
  input logic [N_MST-1:0]  req_write,
  input logic [N_MST-1:0]  req_excl,
  input logic [N_MST-1:0]  req_err,
  input logic [N_MST-1:0]  exokay,
  input logic [N_MST-1:0]  wr_suppress
);

  // R1
  reset_clears_en_chk: assert property (@(posedge clk) rst |=> !en_q);

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == EN_OFFSET && cfg_wdata != '0) |=> en_q);

  for (genvar m = 0; m < N_MST; m++) begin : g_m
    // R11
    idle_okay_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid[m] |-> (exokay[m] == !en_q) && !wr_suppress[m]);

    // R12
    err_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid[m] && req_err[m]) |-> !exokay[m]);

    // R9
    suppress_only_xwr_chk: assert property (@(posedge clk) disable iff (rst)
      wr_suppress[m] |-> (req_valid[m] && req_write[m] && req_excl[m] && en_q));

    // R10
    disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (!en_q && req_valid[m] && !req_err[m]) |-> (exokay[m] && !wr_suppress[m]));

    // R7
    plain_low_chk: assert property (@(posedge clk) disable iff (rst)
      (en_q && req_valid[m] && !req_excl[m]) |-> !exokay[m]);

    // R5
    back_to_back_xwr_chk: assert property (@(posedge clk) disable iff (rst)
      (en_q && req_valid[m] && req_excl[m] && req_write[m]) |=>
      (!(en_q && req_valid[m] && req_excl[m] && req_write[m]) || wr_suppress[m]));
  end

endmodule

bind excl_monitor excl_monitor_chk #(
  .N_MST(N_MST), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .EN_OFFSET(EN_OFFSET)
) u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
  .req_excl(req_excl), .req_err(req_err), .exokay(exokay),
  .wr_suppress(wr_suppress)
);

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;
  localparam int N   = 2;
  localparam int AW  = 32;
  localparam int CAW = 12;
  localparam int CDW = 32;
  localparam logic [AW-1:0] GMASK = 32'hFFFF_FFF8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_we = 1'b0;
  logic [CAW-1:0]     cfg_addr = '0;
  logic [CDW-1:0]     cfg_wdata = '0;
  logic [N-1:0]       req_valid = '0;
  logic [N-1:0][AW-1:0] req_addr = '0;
  logic [N-1:0]       req_write = '0;
  logic [N-1:0]       req_excl = '0;
  logic [N-1:0]       req_err = '0;
  logic [N-1:0]       exokay;
  logic [N-1:0]       wr_suppress;

  always #5 clk = ~clk;

  excl_monitor dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_excl(req_excl), .req_err(req_err),
    .exokay(exokay), .wr_suppress(wr_suppress)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "";
  bit    mv [N];
  logic [AW-1:0] ma [N];
  bit    men;

  task automatic check(string req, logic act, logic exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin mv[k] = 1'b0; ma[k] = '0; end
    men = 1'b0;
  endtask

  // Expected responses from the requirements, masters in index order (R13)
  task automatic evaluate();
    for (int m = 0; m < N; m++) begin
      logic [AW-1:0] g;
      bit ok, sup;
      string r;
      g = req_addr[m] & GMASK;
      ok = 1'b0; sup = 1'b0;
      if (!req_valid[m]) begin ok = !men; r = "R11"; end
      else if (!men) begin ok = 1'b1; r = "R10"; end
      else if (req_excl[m] && !req_write[m]) begin
        ok = 1'b1; mv[m] = 1'b1; ma[m] = g; r = "R3";
      end else if (req_excl[m]) begin
        ok = mv[m] && (ma[m] == g); mv[m] = 1'b0; sup = !ok; r = "R4";
        if (ok) for (int k = 0; k < N; k++) if (k != m && ma[k] == g) mv[k] = 1'b0;
      end else if (req_write[m]) begin
        r = "R7";
        for (int k = 0; k < N; k++) if (k != m && ma[k] == g) mv[k] = 1'b0;
      end else r = "R8";
      if (req_valid[m] && req_err[m]) begin ok = 1'b0; r = "R12"; end
      if (tag != "") r = tag;
      check(r, exokay[m], ok, $sformatf("exokay[%0d]", m));
      check((tag != "") ? tag : "R9", wr_suppress[m], sup, $sformatf("wr_suppress[%0d]", m));
    end
    if (cfg_we && cfg_addr == 12'h018) men = (cfg_wdata != 0);
  endtask

  task automatic idle_inputs();
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = '0; req_addr = '0; req_write = '0; req_excl = '0; req_err = '0;
  endtask

  // called at a falling edge with inputs already driven
  task automatic tick();
    #1;
    evaluate();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic rq(int m, bit w, bit x, bit e, logic [AW-1:0] a);
    req_valid[m] = 1'b1; req_write[m] = w; req_excl[m] = x;
    req_err[m] = e; req_addr[m] = a;
  endtask

  task automatic cfg(logic [CAW-1:0] a, logic [CDW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    tag = "R1";  tick();                                    // idle after reset
    tag = "R2";  cfg(12'h01C, 32'h1); tick(); tick();       // wrong offset ignored
    cfg(12'h018, 32'h100); tick(); tick();                  // nonzero enables
    tag = "R1";  rq(0, 1, 1, 0, 32'h2000); tick();          // no reservation -> fail
    tag = "";
    // R3/R4: reserve and hit with another byte in the same granule
    rq(0, 0, 1, 0, 32'h2004); tick();
    rq(0, 1, 1, 0, 32'h2001); tick();
    // R5: own reservation gone after success
    tag = "R5"; rq(0, 1, 1, 0, 32'h2000); tick();
    // R4 mismatch granule, then R5 cleared after failure
    tag = "R4"; rq(1, 0, 1, 0, 32'h3000); tick(); rq(1, 1, 1, 0, 32'h3008); tick();
    tag = "R5"; rq(1, 1, 1, 0, 32'h3000); tick();
    // R6: matching other cleared, non-matching kept
    tag = "R6";
    rq(0, 0, 1, 0, 32'h4000); tick(); rq(1, 0, 1, 0, 32'h4004); tick();
    rq(0, 1, 1, 0, 32'h4000); tick(); rq(1, 1, 1, 0, 32'h4000); tick();
    rq(1, 0, 1, 0, 32'h4010); tick(); rq(0, 0, 1, 0, 32'h4000); tick();
    rq(0, 1, 1, 0, 32'h4000); tick(); rq(1, 1, 1, 0, 32'h4010); tick();
    // R7: plain write clears other, keeps own
    tag = "R7";
    rq(0, 0, 1, 0, 32'h5000); tick(); rq(1, 0, 1, 0, 32'h5000); tick();
    rq(0, 1, 0, 0, 32'h5004); tick();
    rq(1, 1, 1, 0, 32'h5000); tick(); rq(0, 1, 1, 0, 32'h5000); tick();
    // R8: plain read changes nothing
    tag = "R8";
    rq(0, 0, 1, 0, 32'h5800); tick(); rq(1, 0, 0, 0, 32'h5800); tick();
    rq(0, 0, 0, 0, 32'h5800); tick(); rq(0, 1, 1, 0, 32'h5800); tick();
    // R13: same-cycle collisions, master 0 first
    tag = "R13";
    rq(0, 0, 1, 0, 32'h6000); tick(); rq(1, 0, 1, 0, 32'h6000); tick();
    rq(0, 1, 1, 0, 32'h6000); rq(1, 1, 1, 0, 32'h6004); tick();
    rq(1, 0, 1, 0, 32'h6100); tick();
    rq(0, 1, 0, 0, 32'h6100); rq(1, 1, 1, 0, 32'h6100); tick();
    // R12: error forces low, reservation still taken
    tag = "R12";
    rq(0, 0, 1, 1, 32'h7000); tick(); rq(0, 1, 1, 0, 32'h7000); tick();
    // R10: disabled passes and freezes reservations
    tag = "R10";
    rq(0, 0, 1, 0, 32'h8000); tick();
    cfg(12'h018, 32'h0); tick();
    rq(1, 1, 0, 0, 32'h8000); rq(0, 1, 1, 0, 32'h9000); tick();
    rq(1, 0, 1, 0, 32'h8000); tick();
    cfg(12'h018, 32'h1); tick();
    rq(0, 1, 1, 0, 32'h8000); tick();
    tag = "";

    for (int i = 0; i < 4000; i++) begin
      for (int m = 0; m < N; m++) begin
        if ($urandom_range(0, 3) != 0)
          rq(m, $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0,
             $urandom_range(0, 15) == 0, 32'h1000 + ($urandom_range(0, 7) << 2)
             + $urandom_range(0, 3));
      end
      case ($urandom_range(0, 79))
        0, 1: cfg(12'h018, ($urandom_range(0, 2) != 0) ? $urandom : 32'h0);
        2:    cfg(12'h01C, 32'h0);
        default: ;
      endcase
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule